// File: doc/BRIEF.md
# SDRAM Bank Window Register File

This block holds the configuration state of an SDRAM controller behind a two-port indirect access scheme on a device-control bus. Software first writes an inner index to the index port, then reads or writes the selected inner register through the data window port. The inner registers cover global controller configuration, a read-only status word, refresh and timing words, power-management timing, ECC configuration, ECC error status, the bus-error syndrome and address words, and one configuration word for each memory bank.

Each bank word is decoded into an address window. The window base comes from the upper bits of the word, and the window length is 4 MiB shifted left by a 3-bit code. A bank is live only when its own enable bit and the controller enable are both set. A probe address input is compared against all live windows. The block reports whether any window contains the probe and, if so, the lowest-numbered matching bank. A level interrupt follows whether the ECC error status is nonzero.

Top module: `sdram_bankcfg_regs`

## Requirements
- R1: After reset, the index is 0. The power-management word reads 0x07C00000, the refresh word reads 0x05F00000, the configuration word reads 0x00800000 and the timing word reads all ones. Every other inner register reads 0, ecc_irq is low, no bank is active and no probe hit is reported.
- R2: A read at bus address 0x10 returns the stored index. A write there replaces the index. Accesses at 0x11 go to the inner register the index selects. Reads at any other bus address return 0, and writes there change nothing.
- R3: An unknown inner index reads as all ones, and the timing word (index 0x80) always reads as all ones. Writes to the status word (index 0x24) are ignored. The two bus-error syndrome words (0x00, 0x08) clear the bits written as 1. The bus-error address word (0x10) stores the full written value.
- R4: Written values are masked per register before they are stored. Configuration (0x20) keeps value & 0xFFE00000. Refresh (0x30) keeps value & 0x3FF80000. Power-management (0x34) keeps (value & 0xF8000000) | 0x07C00000. ECC configuration (0x94) keeps value & 0x00F00000.
- R5: Bank word i sits at inner index 0x40 + 4*i and stores value & 0xFFDEE001. Its bank_base output is word & 0xFF800000. Its bank_size output is 0x00400000 << word[19:17].
- R6: Writing the configuration word with bit 31 going from 0 to 1 clears status bit 31. Writing it with bit 31 going from 1 to 0 sets status bit 31. Status changes only on configuration writes.
- R7: When configuration bit 30 goes from 0 to 1, status bit 30 is set. When it goes from 1 to 0, status bit 30 is cleared.
- R8: bank_active[i] is high exactly when bank word i has bit 0 set and configuration bit 31 is set. An inactive bank never produces a hit.
- R9: A bank whose size code is 7 reports bank_size 0 and never produces a hit, even when it is active.
- R10: probe_hit is high when some active bank window satisfies base <= probe_addr < base + size. probe_bank then gives the lowest such bank index. On a miss, probe_bank is 0.
- R11: The ECC error status word (0x98) stores value & 0xFFF0F000. ecc_irq rises when a write makes it nonzero from zero, and falls when a write makes it zero from nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Device-control bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr and stored state |
| probe_addr | input | 32 | Address compared against the bank windows |
| bank_active | output | NBANK | Per-bank live flag |
| bank_base | output | 32*NBANK | Per-bank window base, bank i at bits [32i+31:32i] |
| bank_size | output | 32*NBANK | Per-bank window length in bytes, 0 for the invalid code |
| probe_hit | output | 1 | Some live window contains probe_addr |
| probe_bank | output | SELW | Lowest matching bank index |
| ecc_irq | output | 1 | ECC error interrupt level |

## Verification
Register writes take effect at the clock edge that samples bus_wr. Read data is combinational, so a read issued in the following cycle already shows the new value. The same holds for bank_active, bank_base, bank_size and ecc_irq. The probe outputs are purely combinational from probe_addr and the stored bank words, so they are due in the same cycle the probe changes. The bench therefore drives inputs on the falling edge, lets each write pass one rising edge, and samples results a nanosecond after it changes the bus address or the probe.

// File: rtl/sdbk_pkg.sv
package sdbk_pkg;
  // inner register indices (the bank index stride matters to software)
  localparam logic [31:0] IX_BERR0  = 32'h00;
  localparam logic [31:0] IX_BERR1  = 32'h08;
  localparam logic [31:0] IX_BEADR  = 32'h10;
  localparam logic [31:0] IX_CTRL   = 32'h20;
  localparam logic [31:0] IX_STAT   = 32'h24;
  localparam logic [31:0] IX_RFSH   = 32'h30;
  localparam logic [31:0] IX_PWR    = 32'h34;
  localparam logic [31:0] IX_BANK0  = 32'h40;
  localparam logic [31:0] IX_ECCCTL = 32'h94;
  localparam logic [31:0] IX_ECCERR = 32'h98;

  localparam logic [31:0] MSK_CTRL   = 32'hFFE0_0000;
  localparam logic [31:0] MSK_BANK   = 32'hFFDE_E001;
  localparam logic [31:0] MSK_RFSH   = 32'h3FF8_0000;
  localparam logic [31:0] MSK_PWR    = 32'hF800_0000;
  localparam logic [31:0] FRC_PWR    = 32'h07C0_0000;
  localparam logic [31:0] MSK_ECCCTL = 32'h00F0_0000;
  localparam logic [31:0] MSK_ECCERR = 32'hFFF0_F000;
  localparam logic [31:0] MSK_BASE   = 32'hFF80_0000;

  localparam logic [31:0] RST_CTRL = 32'h0080_0000;
  localparam logic [31:0] RST_RFSH = 32'h05F0_0000;
  localparam logic [31:0] RST_PWR  = 32'h07C0_0000;

  localparam int CTRL_EN  = 31;
  localparam int CTRL_AUX = 30;

  function automatic logic [31:0] bank_index(input int i);
    return IX_BANK0 + 32'(4 * i);
  endfunction

  // window length in bytes; the all-ones code gives an empty window
  function automatic logic [31:0] bank_bytes(input logic [2:0] code);
    return (code == 3'd7) ? 32'd0 : (32'h0040_0000 << code);
  endfunction

  function automatic logic window_has(input logic [31:0] a, input logic [31:0] base,
                                      input logic [31:0] len);
    logic [32:0] lim;
    lim = {1'b0, base} + {1'b0, len};
    return ({1'b0, a} >= {1'b0, base}) && ({1'b0, a} < lim);
  endfunction
endpackage

// File: rtl/sdbk_regs.sv
module sdbk_regs
  import sdbk_pkg::*;
#(
  parameter int AW = 10,
  parameter int NBANK = 4,
  parameter logic [AW-1:0] IDX_PORT = 10'h010,
  parameter logic [AW-1:0] DAT_PORT = 10'h011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               ctrl_en_o,
  output logic [NBANK*32-1:0] bank_words_o,
  output logic               ecc_irq_o
);
  logic [31:0] idx_q, berr0_q, berr1_q, beadr_q, ctrl_q, stat_q;
  logic [31:0] rfsh_q, pwr_q, eccctl_q, eccerr_q;
  logic [31:0] bank_q [NBANK];
  logic        ecc_irq_q;
  logic [31:0] inner_rd;

  // named events
  logic        idx_wr, dat_wr, ctrl_wr_ev;
  logic [31:0] ctrl_new;
  logic        en_rise_ev, en_fall_ev, aux_rise_ev, aux_fall_ev;

  assign idx_wr      = bus_wr && (bus_addr == IDX_PORT);
  assign dat_wr      = bus_wr && (bus_addr == DAT_PORT);
  assign ctrl_wr_ev  = dat_wr && (idx_q == IX_CTRL);
  assign ctrl_new    = bus_wdata & MSK_CTRL;
  assign en_rise_ev  = ctrl_wr_ev && !ctrl_q[CTRL_EN]  &&  ctrl_new[CTRL_EN];
  assign en_fall_ev  = ctrl_wr_ev &&  ctrl_q[CTRL_EN]  && !ctrl_new[CTRL_EN];
  assign aux_rise_ev = ctrl_wr_ev && !ctrl_q[CTRL_AUX] &&  ctrl_new[CTRL_AUX];
  assign aux_fall_ev = ctrl_wr_ev &&  ctrl_q[CTRL_AUX] && !ctrl_new[CTRL_AUX];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      berr0_q   <= '0;
      berr1_q   <= '0;
      beadr_q   <= '0;
      ctrl_q    <= RST_CTRL;
      stat_q    <= '0;
      rfsh_q    <= RST_RFSH;
      pwr_q     <= RST_PWR;
      eccctl_q  <= '0;
      eccerr_q  <= '0;
      ecc_irq_q <= 1'b0;
      for (int i = 0; i < NBANK; i++) bank_q[i] <= '0;
    end else begin
      if (idx_wr) idx_q <= bus_wdata;
      if (dat_wr) begin
        case (idx_q)
          IX_BERR0:  berr0_q  <= berr0_q & ~bus_wdata;
          IX_BERR1:  berr1_q  <= berr1_q & ~bus_wdata;
          IX_BEADR:  beadr_q  <= bus_wdata;
          IX_CTRL: begin
            ctrl_q <= ctrl_new;
            if (en_rise_ev)       stat_q[CTRL_EN] <= 1'b0;
            else if (en_fall_ev)  stat_q[CTRL_EN] <= 1'b1;
            if (aux_rise_ev)      stat_q[CTRL_AUX] <= 1'b1;
            else if (aux_fall_ev) stat_q[CTRL_AUX] <= 1'b0;
          end
          IX_RFSH:   rfsh_q   <= bus_wdata & MSK_RFSH;
          IX_PWR:    pwr_q    <= (bus_wdata & MSK_PWR) | FRC_PWR;
          IX_ECCCTL: eccctl_q <= bus_wdata & MSK_ECCCTL;
          IX_ECCERR: begin
            eccerr_q  <= bus_wdata & MSK_ECCERR;
            ecc_irq_q <= (bus_wdata & MSK_ECCERR) != 32'd0;
          end
          default: ;
        endcase
        for (int i = 0; i < NBANK; i++)
          if (idx_q == bank_index(i)) bank_q[i] <= bus_wdata & MSK_BANK;
      end
    end
  end

  always_comb begin
    case (idx_q)
      IX_BERR0:  inner_rd = berr0_q;
      IX_BERR1:  inner_rd = berr1_q;
      IX_BEADR:  inner_rd = beadr_q;
      IX_CTRL:   inner_rd = ctrl_q;
      IX_STAT:   inner_rd = stat_q;
      IX_RFSH:   inner_rd = rfsh_q;
      IX_PWR:    inner_rd = pwr_q;
      IX_ECCCTL: inner_rd = eccctl_q;
      IX_ECCERR: inner_rd = eccerr_q;
      default:   inner_rd = '1;
    endcase
    for (int i = 0; i < NBANK; i++)
      if (idx_q == bank_index(i)) inner_rd = bank_q[i];
  end

  always_comb begin
    if (bus_addr == IDX_PORT)      bus_rdata = idx_q;
    else if (bus_addr == DAT_PORT) bus_rdata = inner_rd;
    else                           bus_rdata = '0;
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_flat
    assign bank_words_o[g*32 +: 32] = bank_q[g];
  end

  assign ctrl_en_o = ctrl_q[CTRL_EN];
  assign ecc_irq_o = ecc_irq_q;

  AST_IRQ_FOLLOWS_ESR: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_irq_q == (eccerr_q != 32'd0)); // R11
  AST_STAT_ONLY_ON_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr_ev |=> $stable(stat_q)); // R6
  AST_EN_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise_ev |=> !stat_q[CTRL_EN]); // R6
  AST_AUX_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    aux_rise_ev |=> stat_q[CTRL_AUX]); // R7
endmodule

// File: rtl/sdbk_bank_dec.sv
module sdbk_bank_dec
  import sdbk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] word_i,
  input  logic        ctrl_en_i,
  input  logic [31:0] probe_i,
  output logic        active_o,
  output logic [31:0] base_o,
  output logic [31:0] size_o,
  output logic        hit_o
);
  logic [2:0] code;

  assign code     = word_i[19:17];
  assign base_o   = word_i & MSK_BASE;
  assign size_o   = bank_bytes(code);
  assign active_o = word_i[0] && ctrl_en_i;
  assign hit_o    = active_o && window_has(probe_i, base_o, size_o);

  AST_BAD_CODE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (word_i[19:17] == 3'd7) |-> !hit_o); // R9
  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_i[0] && ctrl_en_i) |-> !hit_o); // R8
  AST_SIZE_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(size_o) <= 1); // R5
endmodule

// File: rtl/sdbk_probe_sel.sv
module sdbk_probe_sel #(
  parameter int NBANK = 4,
  localparam int SELW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBANK-1:0] hit_vec_i,
  output logic             hit_o,
  output logic [SELW-1:0]  sel_o
);
  always_comb begin
    hit_o = 1'b0;
    sel_o = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (hit_vec_i[i]) begin
        hit_o = 1'b1;
        sel_o = SELW'(i);
      end
    end
  end

  AST_SEL_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> hit_vec_i[sel_o]); // R10
  AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (hit_vec_i == '0 && sel_o == '0)); // R10
  AST_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> ((hit_vec_i & ((NBANK'(1) << sel_o) - NBANK'(1))) == '0)); // R10
endmodule

// File: rtl/sdram_bankcfg_regs.sv
module sdram_bankcfg_regs #(
  parameter int AW = 10,
  parameter int NBANK = 4,
  parameter logic [AW-1:0] IDX_PORT = 10'h010,
  parameter logic [AW-1:0] DAT_PORT = 10'h011,
  localparam int SELW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        bus_addr,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [31:0]          probe_addr,
  output logic [NBANK-1:0]     bank_active,
  output logic [NBANK*32-1:0]  bank_base,
  output logic [NBANK*32-1:0]  bank_size,
  output logic                 probe_hit,
  output logic [SELW-1:0]      probe_bank,
  output logic                 ecc_irq
);
  logic               ctrl_en;
  logic [NBANK*32-1:0] words;
  logic [NBANK-1:0]   hit_vec;

  sdbk_regs #(.AW(AW), .NBANK(NBANK), .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl_en_o(ctrl_en),
    .bank_words_o(words), .ecc_irq_o(ecc_irq)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    sdbk_bank_dec u_dec (
      .clk(clk), .rst_n(rst_n), .word_i(words[g*32 +: 32]), .ctrl_en_i(ctrl_en),
      .probe_i(probe_addr), .active_o(bank_active[g]),
      .base_o(bank_base[g*32 +: 32]), .size_o(bank_size[g*32 +: 32]),
      .hit_o(hit_vec[g])
    );
  end

  sdbk_probe_sel #(.NBANK(NBANK)) u_sel (
    .clk(clk), .rst_n(rst_n), .hit_vec_i(hit_vec), .hit_o(probe_hit), .sel_o(probe_bank)
  );
endmodule

// File: tb/tb_sdram_bankcfg_regs.sv
`timescale 1ns/1ps
module tb_sdram_bankcfg_regs;
  localparam int NB = 4;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, bus_wr, probe_hit, ecc_irq;
  logic [9:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, probe_addr;
  logic [NB-1:0] bank_active;
  logic [NB*32-1:0] bank_base, bank_size;
  logic [1:0] probe_bank;

  sdram_bankcfg_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .probe_addr(probe_addr),
    .bank_active(bank_active), .bank_base(bank_base), .bank_size(bank_size),
    .probe_hit(probe_hit), .probe_bank(probe_bank), .ecc_irq(ecc_irq)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] mw [NB];
  logic mcfg_en;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic iwr(input logic [31:0] ix, input logic [31:0] d);
    bwr(10'h010, ix); bwr(10'h011, d);
  endtask

  task automatic ichk(input string req, input logic [31:0] ix, input logic [31:0] exp);
    bwr(10'h010, ix); bus_addr = 10'h011; #1; chk(req, bus_rdata, exp);
  endtask

  function automatic logic [31:0] m_size(input logic [31:0] w);
    int c = int'(w[19:17]);
    if (c == 7) return 32'd0;
    return 32'd4 * 32'd1048576 * (32'd1 << c);
  endfunction

  // expected probe result from the requirements
  task automatic probe_chk(input logic [31:0] a);
    logic eh = 1'b0; int es = 0;
    for (int i = 0; i < NB; i++) begin
      longint b = longint'(mw[i] & 32'hFF80_0000);
      longint s = longint'(m_size(mw[i]));
      if (!eh && mw[i][0] && mcfg_en && longint'(a) >= b && longint'(a) < b + s) begin
        eh = 1'b1; es = i;
      end
    end
    @(negedge clk); probe_addr = a; #1;
    chk("R10 hit", {31'd0, probe_hit}, {31'd0, eh});
    chk("R10 bank", {30'd0, probe_bank}, 32'(es));
  endtask

  task automatic out_chk();
    logic [NB-1:0] ea;
    #1;
    for (int i = 0; i < NB; i++) begin
      ea[i] = mw[i][0] & mcfg_en;
      chk("R5 base", bank_base[i*32 +: 32], mw[i] & 32'hFF80_0000);
      chk("R9 size", bank_size[i*32 +: 32], m_size(mw[i]));
    end
    chk("R8 active", {28'd0, bank_active}, {28'd0, ea});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; probe_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NB; i++) mw[i] = '0;
    mcfg_en = 1'b0;

    // R1 reset state
    @(negedge clk); bus_addr = 10'h010; #1; chk("R1 index", bus_rdata, 32'h0);
    chk("R1 irq", {31'd0, ecc_irq}, 32'd0);
    chk("R1 hit", {31'd0, probe_hit}, 32'd0);
    out_chk();
    ichk("R1 pwr", 32'h34, 32'h07C0_0000);
    ichk("R1 rfsh", 32'h30, 32'h05F0_0000);
    ichk("R1 timing", 32'h80, 32'hFFFF_FFFF);
    ichk("R1 ctrl", 32'h20, 32'h0080_0000);
    ichk("R1 stat", 32'h24, 32'h0);
    ichk("R1 eccerr", 32'h98, 32'h0);
    ichk("R1 bank1", 32'h44, 32'h0);

    // R2 index / window / other addresses
    iwr(32'h10, 32'hAABB_CCDD);
    ichk("R2 beadr", 32'h10, 32'hAABB_CCDD);
    @(negedge clk); bus_addr = 10'h010; #1; chk("R2 index read", bus_rdata, 32'h10);
    bwr(10'h012, 32'h1234_5678);
    bus_addr = 10'h012; #1; chk("R2 other addr", bus_rdata, 32'h0);
    ichk("R2 other write", 32'h10, 32'hAABB_CCDD);

    // R3
    ichk("R3 unknown", 32'h5C, 32'hFFFF_FFFF);
    iwr(32'h80, 32'h0);
    ichk("R3 timing", 32'h80, 32'hFFFF_FFFF);
    iwr(32'h24, 32'hFFFF_FFFF);
    ichk("R3 stat ro", 32'h24, 32'h0);
    iwr(32'h00, 32'hFFFF_FFFF);
    ichk("R3 berr0", 32'h00, 32'h0);
    iwr(32'h08, 32'h0000_00FF);
    ichk("R3 berr1", 32'h08, 32'h0);

    // R4 masks
    iwr(32'h30, 32'hFFFF_FFFF); ichk("R4 rfsh", 32'h30, 32'h3FF8_0000);
    iwr(32'h34, 32'h0);         ichk("R4 pwr0", 32'h34, 32'h07C0_0000);
    iwr(32'h34, 32'hFFFF_FFFF); ichk("R4 pwr1", 32'h34, 32'hFFC0_0000);
    iwr(32'h94, 32'hFFFF_FFFF); ichk("R4 eccctl", 32'h94, 32'h00F0_0000);
    iwr(32'h20, 32'hFFFF_FFFF); ichk("R4 ctrl", 32'h20, 32'hFFE0_0000);
    ichk("R7 aux rise", 32'h24, 32'h4000_0000);
    iwr(32'h20, 32'h0);          ichk("R6 en fall", 32'h24, 32'h8000_0000);
    iwr(32'h20, 32'h8000_0000);  ichk("R6 en rise", 32'h24, 32'h0);
    iwr(32'h20, 32'hC000_0000);  ichk("R7 aux set", 32'h24, 32'h4000_0000);
    iwr(32'h20, 32'h8000_0000);  ichk("R7 aux clr", 32'h24, 32'h0);
    mcfg_en = 1'b1;

    // R11 ecc interrupt
    iwr(32'h98, 32'h000F_0FFF); #1; chk("R11 masked zero", {31'd0, ecc_irq}, 32'd0);
    ichk("R11 esr0", 32'h98, 32'h0);
    iwr(32'h98, 32'hFFFF_FFFF); #1; chk("R11 raise", {31'd0, ecc_irq}, 32'd1);
    ichk("R11 esr1", 32'h98, 32'hFFF0_F000);
    iwr(32'h98, 32'h0);         #1; chk("R11 lower", {31'd0, ecc_irq}, 32'd0);

    // R5 bank mask, directed windows
    iwr(32'h4C, 32'hFFFF_FFFF); ichk("R5 bank mask", 32'h4C, 32'hFFDE_E001);
    iwr(32'h4C, 32'h0);
    mw[0] = 32'h1000_0001; mw[1] = 32'h1004_0001; mw[2] = 32'h400E_0001; mw[3] = 32'h0;
    for (int i = 0; i < NB; i++) iwr(32'h40 + 32'(4 * i), mw[i]);
    out_chk();
    chk("R5 size0", bank_size[31:0], 32'h0040_0000);
    chk("R9 size code7", bank_size[95:64], 32'h0);
    probe_chk(32'h1000_0004);
    chk("R10 overlap lowest", {30'd0, probe_bank}, 32'd0);
    probe_chk(32'h1060_0000);
    chk("R10 second bank", {30'd0, probe_bank}, 32'd1);
    probe_chk(32'h4000_0000);
    chk("R9 no hit", {31'd0, probe_hit}, 32'd0);
    probe_chk(32'h2000_0000);
    iwr(32'h20, 32'h0); mcfg_en = 1'b0;
    out_chk();
    probe_chk(32'h1000_0004);
    chk("R8 ctrl off miss", {31'd0, probe_hit}, 32'd0);

    // random windows and probes
    for (int it = 0; it < 150; it++) begin
      logic [31:0] c;
      c = ($urandom % 4 != 0) ? 32'h8000_0000 : 32'h0;
      iwr(32'h20, c); mcfg_en = c[31];
      for (int i = 0; i < NB; i++) begin
        logic [31:0] w;
        w = $urandom;
        w[31:23] = 9'(($urandom % 4) * 2);
        w[0] = ($urandom % 4) != 0;
        iwr(32'h40 + 32'(4 * i), w);
        mw[i] = w & 32'hFFDE_E001;
      end
      out_chk();
      for (int p = 0; p < 4; p++)
        probe_chk(32'(($urandom % 4) * 32'h0100_0000 + ($urandom % 32'h0200_0000)));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule